// File: doc/BRIEF.md
# Serial Configuration Port with Register Readback

This block is the slave end of a three-wire serial setup port. It holds a bank of 8-bit control registers and shows each one on a flat parallel bus for the logic around it. A master lowers the active-low frame strobe and sends 16 bits on the serial data input. The bits are sampled on rising edges of the serial clock. The first byte is the register address and the second byte is the data.

Bit 0 of register 0x00 selects readback mode. While that bit is clear, a complete frame writes its data byte into the addressed register, and the serial output stays low for the whole time. While the bit is set, the data byte sent by the master is discarded. During those same eight clocks the block shifts out the addressed register, most significant bit first, changing the output on falling edges so the master can sample it on the next rising edge. Readback mode can only be left through the asynchronous hardware reset, because once the bit is set no frame can clear it. The reset returns every register to zero.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame is sent MSB first. Bits 1 to 8 form the address and bits 9 to 16 form the data. With readback off, the data is stored in the addressed register on the 16th rising clock edge.
- R2: While `hw_rst` is high, every register, including the readback bit, is 0x00 and `sdo` is low. After release, frames write again.
- R3: With bit 0 of register 0x00 clear, `sdo` is low at every point of every frame.
- R4: With bit 0 of register 0x00 set, the data byte of a frame is ignored and no register changes.
- R5: With readback on, `sdo` is low while the eight address bits are clocked in.
- R6: With readback on, the master sees register bit 7-k at rising edge 9+k of the frame. The output changes on the falling edge just before that rising edge. A register holding 0x04 produces 0,0,0,0,0,1,0,0.
- R7: If `frame_n` rises before 16 rising edges, the frame is dropped with no write. The next frame starts counting from its first bit.
- R8: An address at or above `NUM_REGS` reads back as 0x00, and writes to it change nothing.
- R9: Register i appears on `regs_flat[8*i+7:8*i]` at all times.
- R10: Bits after the 16th in a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; input sampled on rise, output changes on fall |
| hw_rst | input | 1 | Asynchronous active-high reset of the register bank |
| frame_n | input | 1 | Active-low frame strobe |
| sdi | input | 1 | Serial data in, address then data, MSB first |
| sdo | output | 1 | Serial readback data, low when not reading |
| regs_flat | output | 8*NUM_REGS | All registers side by side, register 0 in the low byte |

## Verification
The bench builds the port with `NUM_REGS` = 6, which is smaller than the default of 8. This leaves addresses 6, 7 and 0xFF unimplemented, so reads of absent registers and discarded writes can be reached with ordinary frames. Six registers are still enough to hold the readback bit, the 0x04 pattern and several distinct bytes at the same time.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int NUM_REGS = 8
) (
  input  logic                  sclk,
  input  logic                  hw_rst,
  input  logic                  frame_n,
  input  logic                  sdi,
  output logic                  sdo,
  output logic [8*NUM_REGS-1:0] regs_flat
);
  localparam int CW = 5;
  localparam logic [CW-1:0] LAST = CW'(15);
  localparam logic [CW-1:0] DONE = CW'(16);
  localparam logic [CW-1:0] ADDR_END = CW'(7);
  localparam logic [CW-1:0] DATA_BEG = CW'(8);

  logic [7:0]    regs [NUM_REGS];
  logic [CW-1:0] cnt;
  logic [14:0]   sh;
  logic [7:0]    rd_q, rd_mux;
  logic          sdo_q;
  wire           ro_en = regs[0][0];
  wire  [7:0]    addr_now = {sh[6:0], sdi};
  wire  [7:0]    waddr = sh[14:7];
  wire  [7:0]    wdata = {sh[6:0], sdi};
  wire           wr_go = (cnt == LAST) && !ro_en;

  always_ff @(posedge sclk or posedge hw_rst or posedge frame_n)
    if (hw_rst || frame_n) cnt <= '0;
    else if (cnt != DONE) cnt <= cnt + 1'b1;

  always_ff @(posedge sclk)
    if (!frame_n && cnt < DONE) sh <= {sh[13:0], sdi};

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(addr_now) == i) rd_mux = regs[i];
  end

  always_ff @(posedge sclk or posedge hw_rst)
    if (hw_rst) rd_q <= '0;
    else if (!frame_n && cnt == ADDR_END) rd_q <= rd_mux;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge sclk or posedge hw_rst)
        if (hw_rst) regs[g] <= '0;
        else if (!frame_n && wr_go && int'(waddr) == g) regs[g] <= wdata;
      assign regs_flat[8*g +: 8] = regs[g];
    end
  endgenerate

  always_ff @(negedge sclk or posedge hw_rst)
    if (hw_rst) sdo_q <= 1'b0;
    else if (!frame_n && ro_en && cnt >= DATA_BEG && cnt <= LAST)
      sdo_q <= rd_q[LAST[2:0] - cnt[2:0]];
    else sdo_q <= 1'b0;

  assign sdo = sdo_q & ~frame_n;

  AST_QUIET_WHEN_OFF: assert property (@(posedge sclk) disable iff (hw_rst) !ro_en |-> !sdo); // R3
  AST_ADDR_PHASE_LOW: assert property (@(posedge sclk) disable iff (hw_rst) (!frame_n && cnt < DATA_BEG) |-> !sdo); // R5
  AST_RO_NO_WRITE: assert property (@(posedge sclk) disable iff (hw_rst) $past(ro_en) |-> $stable(regs_flat)); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge sclk) disable iff (hw_rst) frame_n |=> $stable(regs_flat)); // R7
  AST_CNT_BOUND: assert property (@(posedge sclk) disable iff (hw_rst) cnt <= DONE); // R10
endmodule

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;
  localparam int NR = 6;
  logic sclk = 0, hw_rst = 1, frame_n = 1, sdi = 0;
  logic sdo;
  logic [8*NR-1:0] regs_flat;
  logic [8*NR-1:0] model = '0;
  int checks = 0, fails = 0;
  bit finished = 0;

  serial_cfg_port #(.NUM_REGS(NR)) uut (.sclk(sclk), .hw_rst(hw_rst), .frame_n(frame_n),
    .sdi(sdi), .sdo(sdo), .regs_flat(regs_flat));

  always #10 sclk = ~sclk;

  // {addr, data}; model tracks expected bank
  localparam logic [15:0] VEC [8] = '{
    16'h01A5, 16'h023C, 16'h05FF, 16'h0304,
    16'h00FE, 16'h0677, 16'hFF12, 16'h0481};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] d, input int nbits,
                       output logic [7:0] rd, output logic hi_addr, output logic hi_any);
    logic [15:0] w;
    w = {a, d};
    rd = '0; hi_addr = 0; hi_any = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge sclk); #2;
      frame_n = 0;
      sdi = (i < 16) ? w[15-i] : 1'b1;
      if (sdo) hi_any = 1;
      if (i < 8 && sdo) hi_addr = 1;
      if (i >= 8 && i < 16) rd[15-i] = sdo;
    end
    @(negedge sclk); #2;
    if (sdo) hi_any = 1;
    frame_n = 1; sdi = 0;
    @(negedge sclk); #2;
  endtask

  initial begin
    logic [7:0] rd;
    logic ha, hy;
    repeat (3) @(negedge sclk);
    #2;
    chk("R2 reset regs", 64'(regs_flat), 64'(0));
    chk("R2 reset sdo", 64'(sdo), 64'(0));
    hw_rst = 0;
    @(negedge sclk); #2;

    for (int k = 0; k < 8; k++) begin
      frame(VEC[k][15:8], VEC[k][7:0], 16, rd, ha, hy);
      if (int'(VEC[k][15:8]) < NR) model[8*VEC[k][15:8] +: 8] = VEC[k][7:0];
      chk($sformatf("R1/R8/R9 vector %0d", k), 64'(regs_flat), 64'(model));
      chk($sformatf("R3 sdo low vector %0d", k), 64'(hy), 64'(0));
    end

    frame(8'h02, 8'h99, 10, rd, ha, hy);
    chk("R7 aborted frame no write", 64'(regs_flat), 64'(model));
    frame(8'h02, 8'h6B, 16, rd, ha, hy);
    model[8*2 +: 8] = 8'h6B;
    chk("R7 counter restarts", 64'(regs_flat), 64'(model));

    frame(8'h05, 8'h80, 20, rd, ha, hy);
    model[8*5 +: 8] = 8'h80;
    chk("R10 extra bits ignored", 64'(regs_flat), 64'(model));

    frame(8'h00, 8'h01, 16, rd, ha, hy);
    model[7:0] = 8'h01;
    chk("R1 readback enabled", 64'(regs_flat), 64'(model));

    frame(8'h03, 8'hFF, 16, rd, ha, hy);
    chk("R6 read 0x04 pattern", 64'(rd), 64'(8'h04));
    chk("R5 address phase low", 64'(ha), 64'(0));
    chk("R4 data ignored", 64'(regs_flat), 64'(model));

    frame(8'h01, 8'h00, 16, rd, ha, hy);
    chk("R6 read 0xA5", 64'(rd), 64'(8'hA5));
    frame(8'h00, 8'h00, 16, rd, ha, hy);
    chk("R6 read readback reg", 64'(rd), 64'(8'h01));
    chk("R4 readback bit kept", 64'(regs_flat), 64'(model));
    frame(8'h07, 8'h55, 16, rd, ha, hy);
    chk("R8 unimplemented reads zero", 64'(rd), 64'(0));
    frame(8'h02, 8'h11, 12, rd, ha, hy);
    chk("R7 aborted read leaves sdo low", 64'(sdo), 64'(0));

    @(negedge sclk); #2 hw_rst = 1;
    repeat (2) @(negedge sclk);
    #2;
    chk("R2 reset clears bank", 64'(regs_flat), 64'(0));
    chk("R2 sdo low in reset", 64'(sdo), 64'(0));
    hw_rst = 0;
    model = '0;
    @(negedge sclk); #2;
    frame(8'h01, 8'h55, 16, rd, ha, hy);
    model[15:8] = 8'h55;
    chk("R2 writes after reset", 64'(regs_flat), 64'(model));
    chk("R3 sdo low after reset", 64'(hy), 64'(0));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge sclk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule